// File: doc/BRIEF.md
# 36-bit Boolean Instruction Execute Unit

This unit carries out the boolean-function group of a 36-bit word-addressed processor. A start strobe presents a 4-bit function code, a 2-bit write-back mode, the 4-bit accumulator field (the low four bits of the instruction word) and an effective address already resolved into a 12-bit section and an 18-bit offset, with a flag saying whether the address was formed locally. The unit reads the chosen accumulator from its own 16-entry register file, fetches or stores one memory word through a request/grant port when the mode calls for it, forms any of the sixteen two-input boolean functions of the operand E and the accumulator A, and routes the result.

When it completes, the unit gives a single-cycle `done` pulse, which the pipeline uses as its next-PC strobe. If memory reports a fault, the unit gives a single-cycle `fault` pulse instead. The pulse comes with the faulting word address and a read/write flag, and nothing is written to the accumulators or to memory, so the instruction can be issued again after the fault is serviced. The unit takes a new instruction only when idle.

Top module: `bool_exec_unit`

## Requirements
- R1: After reset `busy`, `done`, `fault` and `mem_req` are low, and every accumulator holds zero.
- R2: The function code is a truth table: result bit i equals `fn_code[{~E[i],~A[i]}]`. So 0 gives zero, 1 gives E&A, 2 gives E&~A, 3 gives E, 4 gives A&~E, 5 gives A, 6 gives E^A, 7 gives E|A, 8 gives ~E&~A, 9 gives ~(E^A), 10 gives ~A, 11 gives E|~A, 12 gives ~E, 13 gives ~E|A, 14 gives ~E|~A, and 15 gives all ones. All results are 36 bits wide.
- R3: Mode 0 (accumulator) takes E from memory at {section,offset} and writes the result only to the accumulator selected by `ac_field`. It never writes memory.
- R4: Mode 1 (immediate) uses the offset, zero-extended to 36 bits, as E and raises no memory request.
- R5: Mode 2 (memory) writes the result to {section,offset} and leaves all accumulators unchanged.
- R6: Mode 3 (both) writes the result to memory first and updates the accumulator only after that write is granted without fault.
- R7: Function codes 0, 5, 10 and 15 do not depend on E and issue no memory read. In modes 2 and 3 they perform only the write.
- R8: Function 3 in mode 2 reads the word and writes the same value back, so memory is unchanged and both accesses are made.
- R9: Function 3 in mode 1 loads the accumulator with (section<<18)|offset. The section is replaced by 1 when the address is local, the offset is at most 15 and the section is greater than 1.
- R10: A faulted read or write aborts the instruction with no accumulator or memory update. It pulses `fault` with `fault_addr` = {section,offset} and `fault_is_write` = 1 for a write fault or 0 for a read fault.
- R11: `done` and `fault` are single-cycle, mutually exclusive pulses. `busy` is high from accepted start to the pulse, and a `start` raised while busy is ignored.
- R12: A memory request holds its address, direction and write data stable until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue strobe, taken only when idle |
| fn_code | input | 4 | Boolean function truth table |
| mode_code | input | 2 | Write-back mode (0 acc, 1 imm, 2 mem, 3 both) |
| ac_field | input | 4 | Accumulator index (instruction bits 3:0) |
| ea_sec | input | 12 | Effective-address section |
| ea_off | input | 18 | Effective-address offset |
| ea_local | input | 1 | Address was formed as a local reference |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse (next-PC strobe) |
| fault | output | 1 | Fault abort pulse |
| fault_addr | output | 30 | Faulting word address {section,offset} |
| fault_is_write | output | 1 | 1 if the faulting access was a write |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 36 | Write data |
| mem_gnt | input | 1 | Grant, completes the request |
| mem_rdata | input | 36 | Read data, valid with grant |
| mem_fault | input | 1 | Access faulted, valid with grant |

## Verification
The embedded assertions check on every cycle that:
- a pending request stays stable until it is granted;
- immediate instructions never raise a request;
- E-independent functions never read;
- accumulator mode never writes;
- a both-mode completion is preceded by a clean write grant;
- the `done` and `fault` pulses last one cycle.

The function values, the section rewrite for immediate set-to-memory, and the absence of accumulator or memory updates after a fault are not visible to a single-cycle property. They are shown only by the bench's scenarios. Those scenarios compare memory contents and dumped accumulators against a reference model under random grant delays and injected faults.

// File: rtl/bxu_pkg.sv
package bxu_pkg;

    localparam int DATA_W   = 36;
    localparam int SECT_W   = 12;
    localparam int OFFS_W   = 18;
    localparam int ACC_NUM  = 16;

    typedef enum logic [1:0] {
        WB_ACC  = 2'd0,
        WB_IMM  = 2'd1,
        WB_MEM  = 2'd2,
        WB_BOTH = 2'd3
    } wb_mode_e;

    // Code value is the truth table indexed by {~E,~A}
    typedef enum logic [3:0] {
        FN_ZERO    = 4'd0,
        FN_AND     = 4'd1,
        FN_E_NA    = 4'd2,
        FN_E       = 4'd3,
        FN_A_NE    = 4'd4,
        FN_A       = 4'd5,
        FN_XOR     = 4'd6,
        FN_OR      = 4'd7,
        FN_NOR     = 4'd8,
        FN_XNOR    = 4'd9,
        FN_NA      = 4'd10,
        FN_E_OR_NA = 4'd11,
        FN_NE      = 4'd12,
        FN_NE_OR_A = 4'd13,
        FN_NAND    = 4'd14,
        FN_ONES    = 4'd15
    } bool_fn_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE,
        ST_FAULT
    } exec_state_e;

    // A function ignores E when its table halves for E=1 and E=0 match
    function automatic logic fn_uses_e(input bool_fn_e f);
        logic [3:0] t;
        t = f;
        return !((t[0] == t[2]) && (t[1] == t[3]));
    endfunction

endpackage

// File: rtl/bxu_boolfn.sv
module bxu_boolfn
    import bxu_pkg::*;
#(
    parameter int WORD_W = DATA_W
)(
    input  bool_fn_e          fn,
    input  logic [WORD_W-1:0] e_op,
    input  logic [WORD_W-1:0] a_op,
    output logic [WORD_W-1:0] y
);
    logic [3:0] table_bits;
    assign table_bits = fn;

    // One 4:1 selector per bit; the function code is the select table
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign y[i] = table_bits[{~e_op[i], ~a_op[i]}];
    end
endmodule

// File: rtl/bxu_acc_rf.sv
module bxu_acc_rf #(
    parameter int WORD_W  = 36,
    parameter int NUM_ACC = 16,
    localparam int IDX_W  = $clog2(NUM_ACC)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] regs_q [NUM_ACC];

    for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[k] <= '0;
            end else if (we && (widx == IDX_W'(k))) begin
                regs_q[k] <= wdata;
            end
        end
    end

    assign rdata = regs_q[ridx];
endmodule

// File: rtl/bxu_imm_opnd.sv
module bxu_imm_opnd
    import bxu_pkg::*;
#(
    parameter int WORD_W    = DATA_W,
    parameter int SEC_W     = SECT_W,
    parameter int OFF_W     = OFFS_W,
    parameter int LOCAL_MAX = ACC_NUM - 1,
    localparam int ADDR_W   = SEC_W + OFF_W
)(
    input  bool_fn_e          fn,
    input  logic [SEC_W-1:0]  sec,
    input  logic [OFF_W-1:0]  off,
    input  logic              is_local,
    output logic [WORD_W-1:0] e_imm
);
    logic [SEC_W-1:0] sec_eff;
    logic             to_global;

    // A local reference into the accumulator range is promoted to section 1
    assign to_global = is_local && (off <= OFF_W'(LOCAL_MAX)) && (sec > SEC_W'(1));
    assign sec_eff   = to_global ? SEC_W'(1) : sec;

    always_comb begin
        e_imm = '0;
        e_imm[OFF_W-1:0] = off;
        if (fn == FN_E) begin
            e_imm[ADDR_W-1:OFF_W] = sec_eff;
        end
    end
endmodule

// File: rtl/bool_exec_unit.sv
module bool_exec_unit
    import bxu_pkg::*;
#(
    parameter int WORD_W  = DATA_W,
    parameter int SEC_W   = SECT_W,
    parameter int OFF_W   = OFFS_W,
    parameter int NUM_ACC = ACC_NUM,
    localparam int ACC_W  = $clog2(NUM_ACC),
    localparam int ADDR_W = SEC_W + OFF_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        fn_code,
    input  logic [1:0]        mode_code,
    input  logic [ACC_W-1:0]  ac_field,
    input  logic [SEC_W-1:0]  ea_sec,
    input  logic [OFF_W-1:0]  ea_off,
    input  logic              ea_local,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              fault_is_write,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_fault
);
    typedef struct packed {
        bool_fn_e         fn;
        wb_mode_e         mode;
        logic [ACC_W-1:0] acc;
        logic [SEC_W-1:0] sec;
        logic [OFF_W-1:0] off;
    } op_ctx_t;

    exec_state_e       state_q, state_d;
    op_ctx_t           ctx_q, ctx_new;
    logic [WORD_W-1:0] a_q, e_q, e_imm, a_rd, result;
    logic              flt_wr_q, acc_we, accept;

    assign ctx_new = '{fn:   bool_fn_e'(fn_code),
                       mode: wb_mode_e'(mode_code),
                       acc:  ac_field,
                       sec:  ea_sec,
                       off:  ea_off};
    assign accept  = start && (state_q == ST_IDLE);

    bxu_acc_rf #(
        .WORD_W  (WORD_W),
        .NUM_ACC (NUM_ACC)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (acc_we),
        .widx  (ctx_q.acc),
        .wdata (result),
        .ridx  (ac_field),
        .rdata (a_rd)
    );

    bxu_imm_opnd #(
        .WORD_W    (WORD_W),
        .SEC_W     (SEC_W),
        .OFF_W     (OFF_W),
        .LOCAL_MAX (NUM_ACC - 1)
    ) u_imm (
        .fn       (ctx_new.fn),
        .sec      (ea_sec),
        .off      (ea_off),
        .is_local (ea_local),
        .e_imm    (e_imm)
    );

    bxu_boolfn #(
        .WORD_W (WORD_W)
    ) u_fn (
        .fn   (ctx_q.fn),
        .e_op (e_q),
        .a_op (a_q),
        .y    (result)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (ctx_new.mode == WB_IMM)       state_d = ST_DONE;
                    else if (fn_uses_e(ctx_new.fn))   state_d = ST_READ;
                    else if (ctx_new.mode == WB_ACC)  state_d = ST_DONE;
                    else                              state_d = ST_WRITE;
                end
            end
            ST_READ: begin
                if (mem_gnt) begin
                    if (mem_fault)                    state_d = ST_FAULT;
                    else if (ctx_q.mode == WB_ACC)    state_d = ST_DONE;
                    else                              state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_gnt) state_d = mem_fault ? ST_FAULT : ST_DONE;
            end
            ST_DONE, ST_FAULT: state_d = ST_IDLE;
            default:           state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ctx_q    <= '0;
            a_q      <= '0;
            e_q      <= '0;
            flt_wr_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                ctx_q <= ctx_new;
                a_q   <= a_rd;
                e_q   <= e_imm;
            end
            if ((state_q == ST_READ) && mem_gnt && !mem_fault) begin
                e_q <= mem_rdata;
            end
            if (((state_q == ST_READ) || (state_q == ST_WRITE)) && mem_gnt && mem_fault) begin
                flt_wr_q <= (state_q == ST_WRITE);
            end
        end
    end

    assign busy           = (state_q != ST_IDLE);
    assign done           = (state_q == ST_DONE);
    assign fault          = (state_q == ST_FAULT);
    assign fault_addr     = {ctx_q.sec, ctx_q.off};
    assign fault_is_write = flt_wr_q;
    assign mem_req        = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign mem_we         = (state_q == ST_WRITE);
    assign mem_addr       = {ctx_q.sec, ctx_q.off};
    assign mem_wdata      = result;
    assign acc_we         = done && (ctx_q.mode != WB_MEM);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))
        else $error("request changed before grant"); // R12

    AST_IMM_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        (busy && (ctx_q.mode == WB_IMM)) |-> !mem_req)
        else $error("immediate instruction touched memory"); // R4

    AST_CONST_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> fn_uses_e(ctx_q.fn))
        else $error("read issued for E-independent function"); // R7

    AST_ACC_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !(mem_we && (ctx_q.mode == WB_ACC)))
        else $error("accumulator mode wrote memory"); // R3

    AST_BOTH_WRITE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (done && (ctx_q.mode == WB_BOTH)) |-> $past(mem_req && mem_we && mem_gnt && !mem_fault))
        else $error("both mode finished without clean write"); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy))
        else $error("done longer than one cycle"); // R11

    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        fault |=> (!fault && !busy && !mem_req))
        else $error("fault longer than one cycle"); // R10
endmodule

// File: tb/bool_exec_unit_tb.sv
module bool_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  fn_code = '0;
    logic [1:0]  mode_code = '0;
    logic [3:0]  ac_field = '0;
    logic [11:0] ea_sec = '0;
    logic [17:0] ea_off = '0;
    logic        ea_local = 1'b0;
    logic        busy, done, fault, fault_is_write, mem_req, mem_we;
    logic [29:0] fault_addr, mem_addr;
    logic [35:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [35:0] mem_rdata = '0;
    logic        mem_fault = 1'b0;

    always #5 clk = ~clk;

    bool_exec_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .fn_code(fn_code), .mode_code(mode_code),
        .ac_field(ac_field), .ea_sec(ea_sec), .ea_off(ea_off), .ea_local(ea_local),
        .busy(busy), .done(done), .fault(fault), .fault_addr(fault_addr),
        .fault_is_write(fault_is_write), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .mem_fault(mem_fault)
    );

    // Memory responder
    logic [35:0] mem [256];
    logic        inj_rd = 1'b0, inj_wr = 1'b0;
    int          rd_grants = 0, wr_grants = 0, wait_cnt = 0;

    function automatic logic [35:0] init_word(input int i);
        return (36'(i) * 36'h0_9E37_79B9) ^ 36'h5_A5A5_A5A5;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] = init_word(i);
            mem_gnt = 1'b0;
        end else if (mem_gnt) begin
            mem_gnt = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt != 0) begin
                wait_cnt--;
            end else begin
                mem_gnt  = 1'b1;
                wait_cnt = $urandom % 3;
                if (mem_we) begin
                    wr_grants++;
                    mem_fault = inj_wr;
                    if (!inj_wr) mem[mem_addr[7:0]] = mem_wdata;
                end else begin
                    rd_grants++;
                    mem_fault = inj_rd;
                    mem_rdata = mem[mem_addr[7:0]];
                end
            end
        end
    end

    // Reference model
    logic [35:0] acc_m [16];
    logic [35:0] mem_m [256];
    int checks = 0, errors = 0;

    function automatic logic [35:0] ref_fn(input int f, input logic [35:0] e, input logic [35:0] a);
        case (f)
            0:  return '0;
            1:  return e & a;
            2:  return e & ~a;
            3:  return e;
            4:  return a & ~e;
            5:  return a;
            6:  return e ^ a;
            7:  return e | a;
            8:  return ~e & ~a;
            9:  return ~(e ^ a);
            10: return ~a;
            11: return e | ~a;
            12: return ~e;
            13: return ~e | a;
            14: return ~e | ~a;
            default: return '1;
        endcase
    endfunction

    function automatic bit needs_e(input int f);
        return !(f == 0 || f == 5 || f == 10 || f == 15);
    endfunction

    function automatic logic [35:0] imm_e(input int f, input int sec, input int off, input bit loc);
        int s;
        s = (loc && off <= 15 && sec > 1) ? 1 : sec;
        if (f == 3) return (36'(s) << 18) | 36'(off);
        return 36'(off);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic exec(input int f, input int m, input int ac, input int sec, input int off,
                        input bit loc, input bit frd, input bit fwr, input int garb, input string req);
        logic [35:0] a, e, res;
        bit   x_flt, x_fw, g_flt;
        int   x_rd, x_wr, rd0, wr0, idx, cyc;
        logic [29:0] faddr;
        bit   fwr_flag;
        idx = off % 256;
        a = acc_m[ac];
        x_flt = 0; x_fw = 0; x_rd = 0; x_wr = 0;
        if (m == 1) begin
            res = ref_fn(f, imm_e(f, sec, off, loc), a);
            acc_m[ac] = res;
        end else begin
            x_rd = needs_e(f) ? 1 : 0;
            if (needs_e(f) && frd) begin
                x_flt = 1;
            end else begin
                e = needs_e(f) ? mem_m[idx] : '0;
                res = ref_fn(f, e, a);
                if (m == 0) acc_m[ac] = res;
                else begin
                    x_wr = 1;
                    if (fwr) begin x_flt = 1; x_fw = 1; end
                    else begin
                        mem_m[idx] = res;
                        if (m == 3) acc_m[ac] = res;
                    end
                end
            end
        end
        inj_rd = frd; inj_wr = fwr;
        rd0 = rd_grants; wr0 = wr_grants;
        @(negedge clk);
        fn_code = 4'(f); mode_code = 2'(m); ac_field = 4'(ac);
        ea_sec = 12'(sec); ea_off = 18'(off); ea_local = loc; start = 1'b1;
        @(negedge clk);
        if (garb >= 0) begin
            fn_code = 4'd15; mode_code = 2'd1; ac_field = 4'(garb);
        end else start = 1'b0;
        cyc = 0;
        while (!(done || fault) && cyc < 60) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        start = 1'b0;
        g_flt = fault; faddr = fault_addr; fwr_flag = fault_is_write;
        chk(done || fault, req, "completion pulse", 36'(done | fault), 36'd1);
        chk(g_flt == x_flt, req, "fault outcome", 36'(g_flt), 36'(x_flt));
        if (x_flt) begin
            chk(faddr == 30'((sec << 18) | off), "R10", "fault address", 36'(faddr), 36'((sec << 18) | off));
            chk(fwr_flag == x_fw, "R10", "fault direction", 36'(fwr_flag), 36'(x_fw));
        end
        chk((rd_grants - rd0) == x_rd, req, "read count", 36'(rd_grants - rd0), 36'(x_rd));
        chk((wr_grants - wr0) == x_wr, req, "write count", 36'(wr_grants - wr0), 36'(x_wr));
        chk(mem[idx] == mem_m[idx], req, "memory word", mem[idx], mem_m[idx]);
        @(negedge clk);
        chk(!done && !fault && !busy, "R11", "pulse width", {33'd0, done, fault, busy}, 36'd0);
    endtask

    // Copy an accumulator to word 255 through memory mode, function A
    task automatic dump(input int ac, input string req);
        exec(5, 2, ac, 0, 255, 0, 0, 0, -1, req);
    endtask

    bit wd_hit = 0;

    initial begin
        for (int i = 0; i < 16; i++) acc_m[i] = '0;
        for (int i = 0; i < 256; i++) mem_m[i] = init_word(i);
        void'($urandom(32'h1234_5678));
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                chk(!busy && !done && !fault && !mem_req, "R1", "reset outputs",
                    {32'd0, busy, done, fault, mem_req}, 36'd0);
                dump(0, "R1");
                dump(15, "R1");
                // R3: load accumulators from memory
                exec(3, 0, 1, 0, 10, 0, 0, 0, -1, "R3");
                exec(3, 0, 2, 0, 11, 0, 0, 0, -1, "R3");
                dump(1, "R3");
                // R2: every function on the same operands
                for (int f = 0; f < 16; f++) begin
                    exec(f, 0, 3, 0, 20, 0, 0, 0, -1, "R2");
                    dump(3, "R2");
                    exec(3, 0, 3, 0, 21, 0, 0, 0, -1, "R2");
                end
                // R4: immediate
                exec(7, 1, 1, 3, 18'h3FFFF, 0, 0, 0, -1, "R4");
                dump(1, "R4");
                // R5: memory mode
                exec(6, 2, 2, 0, 30, 0, 0, 0, -1, "R5");
                dump(2, "R5");
                // R6 and R10: write fault in both mode leaves acc alone
                exec(9, 3, 2, 0, 31, 0, 0, 1, -1, "R6");
                dump(2, "R6");
                exec(9, 3, 2, 0, 31, 0, 0, 0, -1, "R6");
                dump(2, "R6");
                // R7: E-independent functions
                exec(0, 2, 1, 0, 40, 0, 0, 0, -1, "R7");
                exec(10, 3, 1, 0, 41, 0, 0, 0, -1, "R7");
                exec(15, 0, 4, 0, 42, 0, 0, 0, -1, "R7");
                dump(4, "R7");
                // R8: set-to-memory in memory mode
                exec(3, 2, 5, 0, 50, 0, 0, 0, -1, "R8");
                // R9: immediate set-to-memory section rewrite
                exec(3, 1, 6, 5, 15, 1, 0, 0, -1, "R9");
                dump(6, "R9");
                exec(3, 1, 6, 5, 16, 1, 0, 0, -1, "R9");
                dump(6, "R9");
                exec(3, 1, 6, 1, 3, 1, 0, 0, -1, "R9");
                dump(6, "R9");
                exec(3, 1, 6, 7, 3, 0, 0, 0, -1, "R9");
                dump(6, "R9");
                // R10: read fault with a nonzero section
                exec(1, 3, 7, 9, 60, 0, 1, 0, -1, "R10");
                dump(7, "R10");
                // R11: start while busy is ignored
                exec(3, 0, 8, 0, 70, 0, 0, 0, 9, "R11");
                dump(9, "R11");
                dump(8, "R11");
                // R12 and all: random stimulus under random grant delays
                for (int n = 0; n < 400; n++) begin
                    int f, m, ac, sec, off;
                    f = $urandom % 16; m = $urandom % 4; ac = $urandom % 16;
                    sec = $urandom % 4; off = (($urandom % 8) << 8) | ($urandom % 255);
                    exec(f, m, ac, sec, off, 1'($urandom % 2),
                         ($urandom % 8) == 0, ($urandom % 8) == 0, -1, "R12");
                    if (($urandom % 3) == 0) dump($urandom % 16, "R12");
                end
            end
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1;
            end
        join_any
        if (wd_hit) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule